// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles. It retires one quotient bit per cycle and uses a single wide partial-remainder register and one subtractor. A pulse on `start` captures the dividend, the divisor and a mode select that picks unsigned or two's-complement signed operands. When the work is finished, the block drives the quotient and remainder and raises `done` for one cycle. The results stay on the outputs until the next operation completes.

The register is loaded with the dividend magnitude already moved up by one bit, so every cycle spends its subtraction on real work. In each cycle the divisor is taken from the upper part of the register. A non-negative difference is kept and shifts a 1 into the quotient. A negative difference leaves the old value in place and shifts in a 0. Once all quotient bits are formed, the upper part is moved back down one bit to give the true remainder. In signed mode the magnitudes are divided. The signs are then applied so that the quotient is truncated toward zero and the remainder follows the sign of the dividend.

Top module: `seq_divider`

## Requirements
- R1: While and directly after reset, `done` and `div_zero` are 0 and `quotient` and `remainder` are all zeros.
- R2: With `is_signed` = 0, the operands are unsigned. The results satisfy dividend = quotient * divisor + remainder, with remainder < divisor.
- R3: With `is_signed` = 1, the quotient is the magnitude quotient |dividend| / |divisor|, truncated. It is negated when the operand signs differ.
- R4: With `is_signed` = 1, a nonzero remainder has the sign of the dividend, and its magnitude is below the divisor magnitude. Together with R3, dividend = quotient * divisor + remainder holds.
- R5: For a nonzero divisor, `done` rises exactly 33 clock edges after the edge that samples `start` (32 subtract steps plus one correction step). It stays high for exactly one cycle.
- R6: A zero divisor skips the iteration. `done` and `div_zero` both rise on the edge that samples `start`. `quotient` becomes all ones and `remainder` becomes the dividend input, unchanged.
- R7: `start` has no effect while an operation is in progress. The result that is delivered belongs to the operands captured first.
- R8: `quotient` and `remainder` change only on the edge that raises `done`, and hold their values between completions.
- R9: `div_zero` is cleared by the next completion that has a nonzero divisor.
- R10: In signed mode, the most negative value divided by -1 gives quotient 0x80000000 and remainder 0 (the result wraps modulo 2^32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; sampled only while idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| quotient | output | 32 | Quotient result |
| remainder | output | 32 | Remainder result |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last completion had a zero divisor |

## Verification
The assertions watch the protocol on every cycle. They check that `done` is a single-cycle pulse and that the outputs move only when `done` rises. They also check that `div_zero` changes only with a completion and that the step counter advances by one while iterating. In addition, the assertions confirm that the corrected remainder magnitude is below the divisor magnitude. Whether the quotient and remainder values are arithmetically right can only be shown by the bench's scenarios. Those scenarios also cover the sign rules, the overflow wrap, the exact latency, the zero-divisor results and the ignored restart, each compared against a reference computed in the bench.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_t;

    typedef struct packed {
        logic signed_mode;
        logic neg_quot;
        logic neg_rem;
    } div_flags_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] mag_dvd,
    output logic [W-1:0] mag_dvs,
    output div_flags_t   flags,
    output logic         dvs_is_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic dvd_neg, dvs_neg;

    always_comb begin
        dvd_neg = is_signed & dividend[W-1];
        dvs_neg = is_signed & divisor[W-1];
        mag_dvd = dvd_neg ? (~dividend + ONE) : dividend;
        mag_dvs = dvs_neg ? (~divisor + ONE) : divisor;
        flags.signed_mode = is_signed;
        flags.neg_quot    = dvd_neg ^ dvs_neg;
        flags.neg_rem     = dvd_neg;
        dvs_is_zero       = (divisor == '0);
    end
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit #(
    parameter int W = 32
) (
    input  logic [2*W:0] rem_in,
    input  logic [W-1:0] dvs,
    output logic [2*W:0] rem_out
);
    logic [W:0]   upper;
    logic [W+1:0] diff;
    logic         fits;
    logic [W:0]   kept;

    always_comb begin
        upper   = rem_in[2*W:W];
        diff    = {1'b0, upper} - {2'b00, dvs};
        fits    = ~diff[W+1];
        kept    = fits ? diff[W:0] : upper;
        // kept < dvs < 2^W, so its top bit is always zero and may be dropped
        rem_out = {kept[W-1:0], rem_in[W-1:0], fits};
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] mag_q,
    input  logic [W-1:0] mag_r,
    input  div_flags_t   flags,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        q_out = (flags.signed_mode && flags.neg_quot) ? (~mag_q + ONE) : mag_q;
        r_out = (flags.signed_mode && flags.neg_rem)  ? (~mag_r + ONE) : mag_r;
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         done,
    output logic         div_zero
);
    localparam int RW = 2 * W + 1;
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_t   state;
    logic [RW-1:0] rem_reg;
    logic [W-1:0]  dvs_reg;
    div_flags_t    flags_reg;
    logic [CW-1:0] cnt;

    logic [W-1:0]  prep_dvd, prep_dvs;
    div_flags_t    prep_flags;
    logic          prep_zero;
    logic [RW-1:0] step_out;
    logic [W-1:0]  fix_q, fix_r;
    logic [W-1:0]  corr_rem;

    div_operand_prep #(.W(W)) u_prep (
        .is_signed   (is_signed),
        .dividend    (dividend),
        .divisor     (divisor),
        .mag_dvd     (prep_dvd),
        .mag_dvs     (prep_dvs),
        .flags       (prep_flags),
        .dvs_is_zero (prep_zero)
    );

    div_step_unit #(.W(W)) u_step (
        .rem_in  (rem_reg),
        .dvs     (dvs_reg),
        .rem_out (step_out)
    );

    // final correction: upper half moved back down by one bit
    assign corr_rem = rem_reg[RW-1:W+1];

    div_sign_fix #(.W(W)) u_fix (
        .mag_q (rem_reg[W-1:0]),
        .mag_r (corr_rem),
        .flags (flags_reg),
        .q_out (fix_q),
        .r_out (fix_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rem_reg   <= '0;
            dvs_reg   <= '0;
            flags_reg <= '0;
            cnt       <= '0;
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b0;
            div_zero  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (prep_zero) begin
                            quotient  <= '1;
                            remainder <= dividend;
                            div_zero  <= 1'b1;
                            done      <= 1'b1;
                        end else begin
                            rem_reg   <= {W'(0), prep_dvd, 1'b0};
                            dvs_reg   <= prep_dvs;
                            flags_reg <= prep_flags;
                            cnt       <= '0;
                            state     <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    rem_reg <= step_out;
                    cnt     <= cnt + CW'(1);
                    if (cnt == LAST) state <= ST_FIX;
                end
                ST_FIX: begin
                    quotient  <= fix_q;
                    remainder <= fix_r;
                    div_zero  <= 1'b0;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: results move only together with a completion
    a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder)));

    // R6: the zero-divisor flag only appears with a completion
    a_r6_zero_flag_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(div_zero) |-> done);

    // R9: the flag is only cleared by a completion
    a_r9_zero_flag_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(div_zero) |-> done);

    // R7: once running, each cycle advances the step count regardless of start
    a_r7_run_advances: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cnt != LAST) |=>
            (state == ST_RUN && cnt == $past(cnt) + CW'(1)));

    // R4: corrected remainder magnitude is below the divisor magnitude
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIX) |-> (corr_rem < dvs_reg));
endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient, remainder;
    logic         done, div_zero;

    int n_checks = 0;
    int n_fail   = 0;

    seq_divider #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder),
        .done(done), .div_zero(div_zero)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model(input logic sm, input logic [W-1:0] a, input logic [W-1:0] b,
                                  output logic [W-1:0] q, output logic [W-1:0] r);
        longint la, lb;
        if (sm) begin
            la = longint'($signed(a));
            lb = longint'($signed(b));
        end else begin
            la = longint'({32'b0, a});
            lb = longint'({32'b0, b});
        end
        q = W'(la / lb);
        r = W'(la % lb);
    endfunction

    // issue one operation; returns edge count from the start edge to done
    task automatic run_div(input logic sm, input logic [W-1:0] a, input logic [W-1:0] b,
                           output int lat);
        @(negedge clk);
        is_signed = sm; dividend = a; divisor = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic do_and_check(input string req, input logic sm,
                                input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] eq, er;
        int lat;
        model(sm, a, b, eq, er);
        run_div(sm, a, b, lat);
        check({req, " quotient"}, quotient, eq);
        check({req, " remainder"}, remainder, er);
        check("R5 latency", W'(lat), W'(W + 1));
        check("R9 div_zero low", W'(div_zero), W'(0));
        @(negedge clk);
        check("R5 done one cycle", W'(done), W'(0));
    endtask

    task automatic t_reset();
        check("R1 done", W'(done), W'(0));
        check("R1 div_zero", W'(div_zero), W'(0));
        check("R1 quotient", quotient, '0);
        check("R1 remainder", remainder, '0);
    endtask

    task automatic t_unsigned();
        do_and_check("R2 u 100/7", 1'b0, 32'd100, 32'd7);
        do_and_check("R2 u max/1", 1'b0, 32'hFFFF_FFFF, 32'd1);
        do_and_check("R2 u max/max", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_and_check("R2 u small/big", 1'b0, 32'd5, 32'h8000_0000);
        do_and_check("R2 u big/3", 1'b0, 32'hF000_0001, 32'd3);
        do_and_check("R2 u msb divisor", 1'b0, 32'hFFFF_FFFE, 32'h8000_0001);
    endtask

    task automatic t_signed();
        do_and_check("R3 s +7/+2", 1'b1, 32'd7, 32'd2);
        do_and_check("R3 s -7/+2", 1'b1, -32'sd7, 32'd2);
        do_and_check("R4 s +7/-2", 1'b1, 32'd7, -32'sd2);
        do_and_check("R4 s -7/-2", 1'b1, -32'sd7, -32'sd2);
        do_and_check("R4 s -100/3", 1'b1, -32'sd100, 32'd3);
        do_and_check("R3 s min/2", 1'b1, 32'h8000_0000, 32'd2);
    endtask

    task automatic t_overflow();
        do_and_check("R10 min/-1", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
        check("R10 quotient literal", quotient, 32'h8000_0000);
        check("R10 remainder literal", remainder, 32'h0);
    endtask

    task automatic t_divzero();
        int lat;
        run_div(1'b0, 32'h1234_5678, 32'd0, lat);
        check("R6 latency", W'(lat), W'(0));
        check("R6 flag", W'(div_zero), W'(1));
        check("R6 quotient", quotient, 32'hFFFF_FFFF);
        check("R6 remainder", remainder, 32'h1234_5678);
        dividend = 32'hDEAD_BEEF;
        divisor  = 32'd9;
        repeat (5) @(negedge clk);
        check("R8 hold quotient", quotient, 32'hFFFF_FFFF);
        check("R8 hold remainder", remainder, 32'h1234_5678);
        check("R6 flag held", W'(div_zero), W'(1));
        do_and_check("R9 clear after zero", 1'b0, 32'd50, 32'd6);
    endtask

    task automatic t_busy();
        logic [W-1:0] eq, er;
        int lat;
        model(1'b0, 32'd1000, 32'd33, eq, er);
        @(negedge clk);
        is_signed = 1'b0; dividend = 32'd1000; divisor = 32'd33; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
        is_signed = 1'b1; dividend = 32'hFFFF_0000; divisor = 32'd0; start = 1'b1;
        @(posedge clk); lat++; @(negedge clk);
        start = 1'b0;
        while (!done && lat < 100) begin @(posedge clk); lat++; @(negedge clk); end
        check("R7 latency unaffected", W'(lat), W'(W + 1));
        check("R7 quotient of first operands", quotient, eq);
        check("R7 remainder of first operands", remainder, er);
        check("R7 no zero flag", W'(div_zero), W'(0));
        repeat (3) @(negedge clk);
        check("R7 no second completion", W'(done), W'(0));
        check("R8 hold after done", quotient, eq);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_overflow();
        t_divzero();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule